// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit datapath of a multicycle load/store processor. It holds the program counter, the instruction register, the memory data register, two operand registers, an ALU result register and a 32-entry register file. Around these sit sign extension, operand selection and an ALU. Every instruction takes several clock cycles. In each cycle an external sequencer drives a set of control strobes and selects, and the datapath latches that step's results into its internal registers. Those latched values are the stable inputs for the next step.

One shared memory port carries both instruction fetches and data accesses. The port has an address, write data, read data, a read strobe and a write strobe. The memory is word-addressed, so the program counter advances by one per instruction. The top six bits of the instruction register go out to the sequencer as the opcode. Instruction fields follow a fixed format:

- The first source register is in bits 25:21.
- The second source register, which is also the load destination, is in bits 20:16.
- The R-type destination is in bits 15:11.
- The immediate is in bits 15:0.
- The jump index is in bits 25:0.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, all internal registers are cleared. After reset, with `ctl_iord`=0, `mem_addr` reads 0 and `opcode` reads 0.
- R2: A fetch step loads the instruction register from `mem_rdata` at address PC. The step drives `ctl_iord`=0, `ctl_ir_wr`=1, `ctl_alu_a_sel`=0 (PC), `ctl_alu_b_sel`=1 (constant 1), `ctl_alu_op`=ADD, `ctl_pc_wr`=1 and `ctl_pc_src`=0 (ALU output). The PC becomes PC+1.
- R3: A decode step drives `ctl_ab_wr`=1. It loads operand A from register IR[25:21] and operand B from register IR[20:16]. It also drives `ctl_alu_a_sel`=0, `ctl_alu_b_sel`=2 (sign-extended IR[15:0]) and `ctl_aluout_wr`=1, which loads ALUOut with PC plus the sign-extended offset.
- R4: `ctl_alu_op` selects the ALU function. The codes are 0 add, 1 subtract, 2 AND, 3 OR and 4 signed set-less-than (result 1 or 0). Codes 5 to 7 give zero. `ctl_alu_a_sel`=1 selects operand A. `ctl_alu_b_sel`=0 selects operand B, and 3 selects zero.
- R5: For a load, the address step loads ALUOut with A plus sign-extended IR[15:0]. Then `ctl_iord`=1 with `ctl_mdr_wr`=1 loads the MDR from memory at ALUOut. Then `ctl_reg_wr`=1, `ctl_reg_dst`=0 and `ctl_mem_to_reg`=1 write the MDR to register IR[20:16].
- R6: With `ctl_iord`=1, `mem_addr` is ALUOut. `mem_wdata` is always operand B. `mem_rd` and `mem_wr` follow `ctl_mem_rd` and `ctl_mem_wr`, so a store writes B at ALUOut.
- R7: `ctl_reg_wr`=1 with `ctl_reg_dst`=1 and `ctl_mem_to_reg`=0 writes ALUOut to register IR[15:11].
- R8: With `ctl_pc_wr_cond`=1 and `ctl_pc_src`=1, the PC takes ALUOut only when A equals B. Otherwise the PC keeps its value.
- R9: With `ctl_pc_wr`=1 and `ctl_pc_src`=2, the PC becomes {PC[31:26], IR[25:0]}.
- R10: Register 0 reads as zero, and writes addressed to it have no effect.
- R11: Each internal register keeps its value in any cycle where its load enable is low. For the PC, that means both `ctl_pc_wr` and `ctl_pc_wr_cond` are low.
- R12: `opcode` always equals IR[31:26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_pc_wr | input | 1 | Unconditional PC load |
| ctl_pc_wr_cond | input | 1 | PC load when A equals B |
| ctl_pc_src | input | 2 | PC source: 0 ALU output, 1 ALUOut, 2 jump target |
| ctl_ir_wr | input | 1 | Instruction register load |
| ctl_mdr_wr | input | 1 | Memory data register load |
| ctl_ab_wr | input | 1 | Operand A/B load from register file |
| ctl_aluout_wr | input | 1 | ALUOut load |
| ctl_iord | input | 1 | Memory address select: 0 PC, 1 ALUOut |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_alu_a_sel | input | 1 | ALU first operand: 0 PC, 1 A |
| ctl_alu_b_sel | input | 2 | ALU second operand: 0 B, 1 one, 2 immediate, 3 zero |
| ctl_alu_op | input | 3 | ALU function code |
| ctl_reg_wr | input | 1 | Register file write enable |
| ctl_reg_dst | input | 1 | Write index: 0 IR[20:16], 1 IR[15:11] |
| ctl_mem_to_reg | input | 1 | Write data: 0 ALUOut, 1 MDR |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction opcode to the sequencer |

## Verification
The assertions assume the sequencer never raises the read and write strobes together, and that control inputs are settled before each rising edge. The bench acts as the sequencer. Every instruction it issues is a legal step sequence (fetch, decode, then the steps for R-type, load, store, branch or jump), and each step sets exactly one mutually exclusive strobe pattern at the falling edge. Random programs keep the program counter in the low half of a 256-word memory and all data accesses in the high half, so instruction placement never overwrites data.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'd0,
        PCS_ALUOUT = 2'd1,
        PCS_JUMP   = 2'd2
    } pc_src_e;

    typedef enum logic [1:0] {
        BSEL_B    = 2'd0,
        BSEL_ONE  = 2'd1,
        BSEL_IMM  = 2'd2,
        BSEL_ZERO = 2'd3
    } b_sel_e;

    localparam int unsigned WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] mdr;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] aluout;
    } dp_state_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res
);

    logic [W-1:0] diff;

    always_comb begin
        diff = x - y;
        res  = '0;
        case (alu_op_e'(op))
            ALU_ADD: res = x + y;
            ALU_SUB: res = diff;
            ALU_AND: res = x & y;
            ALU_OR:  res = x | y;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int unsigned W = 32,
    parameter int unsigned N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] ra1,
    input  logic [$clog2(N)-1:0] ra2,
    output logic [W-1:0]         rd1,
    output logic [W-1:0]         rd2,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);

    localparam int unsigned AW = $clog2(N);

    logic [W-1:0] regs_d [N];
    logic [W-1:0] regs_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) regs_d[i] = regs_q[i];
        if (we && (wa != '0)) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs_q[ra2];

    AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != '0)) |=> (regs_q[$past(wa)] == $past(wd))); // R7

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_N  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_pc_wr,
    input  logic              ctl_pc_wr_cond,
    input  logic [1:0]        ctl_pc_src,
    input  logic              ctl_ir_wr,
    input  logic              ctl_mdr_wr,
    input  logic              ctl_ab_wr,
    input  logic              ctl_aluout_wr,
    input  logic              ctl_iord,
    input  logic              ctl_mem_rd,
    input  logic              ctl_mem_wr,
    input  logic              ctl_alu_a_sel,
    input  logic [1:0]        ctl_alu_b_sel,
    input  logic [2:0]        ctl_alu_op,
    input  logic              ctl_reg_wr,
    input  logic              ctl_reg_dst,
    input  logic              ctl_mem_to_reg,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [5:0]        opcode
);

    localparam int unsigned RA_W  = $clog2(REG_N);
    localparam int unsigned IMM_W = 16;
    localparam int unsigned JMP_W = 26;

    dp_state_t st_d, st_q;

    logic [DATA_W-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [RA_W-1:0]   rf_wa;
    logic [DATA_W-1:0] imm_sx, jump_tgt, alu_x, alu_y, alu_res, pc_next;
    logic              br_taken;

    mc_regfile #(.W(DATA_W), .N(REG_N)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (st_q.ir[25:21]),
        .ra2   (st_q.ir[20:16]),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2),
        .we    (ctl_reg_wr),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    mc_alu #(.W(DATA_W)) i_alu (
        .op  (ctl_alu_op),
        .x   (alu_x),
        .y   (alu_y),
        .res (alu_res)
    );

    always_comb begin
        imm_sx   = {{(DATA_W-IMM_W){st_q.ir[IMM_W-1]}}, st_q.ir[IMM_W-1:0]};
        jump_tgt = {st_q.pc[DATA_W-1:JMP_W], st_q.ir[JMP_W-1:0]};
        alu_x    = ctl_alu_a_sel ? st_q.a : st_q.pc;
        case (b_sel_e'(ctl_alu_b_sel))
            BSEL_B:   alu_y = st_q.b;
            BSEL_ONE: alu_y = DATA_W'(1);
            BSEL_IMM: alu_y = imm_sx;
            default:  alu_y = '0;
        endcase
        case (pc_src_e'(ctl_pc_src))
            PCS_ALUOUT: pc_next = st_q.aluout;
            PCS_JUMP:   pc_next = jump_tgt;
            default:    pc_next = alu_res;
        endcase
        br_taken = ctl_pc_wr_cond && (st_q.a == st_q.b);
        rf_wa    = ctl_reg_dst ? st_q.ir[15:11] : st_q.ir[20:16];
        rf_wd    = ctl_mem_to_reg ? st_q.mdr : st_q.aluout;
    end

    always_comb begin
        st_d = st_q;
        if (ctl_pc_wr || br_taken) st_d.pc = pc_next;
        if (ctl_ir_wr)             st_d.ir = mem_rdata;
        if (ctl_mdr_wr)            st_d.mdr = mem_rdata;
        if (ctl_ab_wr) begin
            st_d.a = rf_rd1;
            st_d.b = rf_rd2;
        end
        if (ctl_aluout_wr)         st_d.aluout = alu_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = ctl_iord ? st_q.aluout : st_q.pc;
    assign mem_wdata = st_q.b;
    assign mem_rd    = ctl_mem_rd;
    assign mem_wr    = ctl_mem_wr;
    assign opcode    = st_q.ir[31:26];

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_pc_wr && !ctl_pc_wr_cond) |=> $stable(st_q.pc)); // R11

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ir_wr |=> $stable(st_q.ir)); // R11

    AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pc_wr_cond && !ctl_pc_wr && (st_q.a != st_q.b)) |=> $stable(st_q.pc)); // R8

    AST_JUMP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pc_wr && (ctl_pc_src == 2'd2)) |=> (st_q.pc[31:26] == $past(st_q.pc[31:26]))); // R9

    AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pc_wr && (ctl_pc_src == 2'd0) && !ctl_alu_a_sel && (ctl_alu_b_sel == 2'd1)
         && (ctl_alu_op == 3'd0)) |=> (st_q.pc == $past(st_q.pc) + 1)); // R2

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6

endmodule

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] pc_src;
        logic       ir_wr;
        logic       mdr_wr;
        logic       ab_wr;
        logic       aluout_wr;
        logic       iord;
        logic       mem_rd;
        logic       mem_wr;
        logic       a_sel;
        logic [1:0] b_sel;
        logic [2:0] op;
        logic       reg_wr;
        logic       reg_dst;
        logic       mem_to_reg;
    } ctl_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    ctl_t        c = '0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic [5:0]  opcode;

    logic [31:0] mem [256];
    logic [31:0] rregs [32];
    logic [31:0] rpc;
    int unsigned errs = 0;
    int unsigned checks = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    mc_datapath i_mc_datapath (
        .clk(clk), .rst_n(rst_n),
        .ctl_pc_wr(c.pc_wr), .ctl_pc_wr_cond(c.pc_wr_cond), .ctl_pc_src(c.pc_src),
        .ctl_ir_wr(c.ir_wr), .ctl_mdr_wr(c.mdr_wr), .ctl_ab_wr(c.ab_wr),
        .ctl_aluout_wr(c.aluout_wr), .ctl_iord(c.iord), .ctl_mem_rd(c.mem_rd),
        .ctl_mem_wr(c.mem_wr), .ctl_alu_a_sel(c.a_sel), .ctl_alu_b_sel(c.b_sel),
        .ctl_alu_op(c.op), .ctl_reg_wr(c.reg_wr), .ctl_reg_dst(c.reg_dst),
        .ctl_mem_to_reg(c.mem_to_reg),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .opcode(opcode)
    );

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] x, y);
        case (op)
            3'd0: return x + y;
            3'd1: return x - y;
            3'd2: return x & y;
            3'd3: return x | y;
            3'd4: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one control step at the falling edge; store writes captured before the rising edge.
    task automatic step(input ctl_t n);
        @(negedge clk);
        c = n;
        #1;
        if (c.mem_wr) mem[mem_addr[7:0]] = mem_wdata;
        @(posedge clk);
    endtask

    task automatic idle_pc_check(input string req);
        @(negedge clk);
        c = '0;
        #0.5;
        chk(mem_addr == rpc, req, mem_addr, rpc);
    endtask

    task automatic fetch_decode(input logic [31:0] instr);
        ctl_t k;
        mem[rpc[7:0]] = instr;
        k = '0; k.ir_wr = 1; k.mem_rd = 1; k.b_sel = 2'd1; k.pc_wr = 1;
        step(k);
        #1;
        chk(opcode == instr[31:26], "R12 opcode after fetch (R2)", {26'd0, opcode}, {26'd0, instr[31:26]});
        rpc = rpc + 1;
        k = '0; k.ab_wr = 1; k.b_sel = 2'd2; k.aluout_wr = 1;
        step(k);
    endtask

    task automatic do_rtype(input logic [4:0] rs, rt, rd, input logic [2:0] op);
        ctl_t k;
        fetch_decode({6'd0, rs, rt, rd, 11'd0});
        k = '0; k.a_sel = 1; k.b_sel = 2'd0; k.op = op; k.aluout_wr = 1;
        step(k);
        k = '0; k.reg_wr = 1; k.reg_dst = 1;
        step(k);
        if (rd != 0) rregs[rd] = ref_alu(op, rregs[rs], rregs[rt]);
        idle_pc_check("R2 pc after R-type (R7)");
    endtask

    task automatic do_load(input logic [4:0] rt, input logic [15:0] imm);
        ctl_t k;
        fetch_decode({6'h23, 5'd0, rt, imm});
        k = '0; k.a_sel = 1; k.b_sel = 2'd2; k.aluout_wr = 1;
        step(k);
        k = '0; k.iord = 1; k.mem_rd = 1; k.mdr_wr = 1;
        step(k);
        k = '0; k.reg_wr = 1; k.mem_to_reg = 1;
        step(k);
        if (rt != 0) rregs[rt] = mem[imm[7:0]];
        idle_pc_check("R2 pc after load (R5)");
    endtask

    task automatic do_store(input logic [4:0] rt, input logic [15:0] imm, input string req);
        ctl_t k;
        fetch_decode({6'h2B, 5'd0, rt, imm});
        k = '0; k.a_sel = 1; k.b_sel = 2'd2; k.aluout_wr = 1;
        step(k);
        k = '0; k.iord = 1; k.mem_wr = 1;
        step(k);
        @(negedge clk);
        c = '0;
        chk(mem[imm[7:0]] == rregs[rt], req, mem[imm[7:0]], rregs[rt]);
        idle_pc_check("R2 pc after store (R6)");
    endtask

    task automatic do_branch(input logic [4:0] rs, rt, input logic [15:0] off, input string req);
        ctl_t k;
        fetch_decode({6'h04, rs, rt, off});
        k = '0; k.a_sel = 1; k.op = 3'd1; k.pc_wr_cond = 1; k.pc_src = 2'd1;
        step(k);
        if (rregs[rs] == rregs[rt]) rpc = rpc + sx16(off);
        idle_pc_check(req);
    endtask

    task automatic do_jump(input logic [25:0] idx);
        ctl_t k;
        fetch_decode({6'h02, idx});
        k = '0; k.pc_wr = 1; k.pc_src = 2'd2;
        step(k);
        rpc = {rpc[31:26], idx};
        idle_pc_check("R9 jump target");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        for (int i = 0; i < 256; i++) mem[i] = (i >= 128) ? $urandom() : 32'd0;
        for (int i = 0; i < 32; i++) rregs[i] = 32'd0;
        rpc = 32'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state
        chk(mem_addr == 32'd0, "R1 mem_addr after reset", mem_addr, 32'd0);
        chk(opcode == 6'd0, "R1 opcode after reset", {26'd0, opcode}, 32'd0);
        chk(!mem_rd && !mem_wr, "R1 strobes idle", {30'd0, mem_rd, mem_wr}, 32'd0);

        // Directed corners
        mem[200] = 32'hFFFF_FFF0;
        mem[201] = 32'd5;
        do_load(5'd1, 16'd200);
        do_load(5'd2, 16'd201);
        do_store(5'd1, 16'd220, "R5 load then store r1");
        do_rtype(5'd1, 5'd2, 5'd3, 3'd4);
        do_store(5'd3, 16'd210, "R4 signed SLT negative < positive");
        do_rtype(5'd2, 5'd1, 5'd4, 3'd4);
        do_store(5'd4, 16'd211, "R4 SLT false gives zero");
        do_rtype(5'd1, 5'd2, 5'd0, 3'd0);
        do_store(5'd0, 16'd212, "R10 write to r0 ignored");
        do_rtype(5'd1, 5'd2, 5'd5, 3'd7);
        do_store(5'd5, 16'd213, "R4 undefined op gives zero");
        do_branch(5'd1, 5'd1, 16'd3, "R8 branch taken (R3 target)");
        do_branch(5'd1, 5'd2, 16'd5, "R8 branch not taken");
        do_jump(26'd20);
        idle_pc_check("R11 pc holds with enables low");

        // Constrained random program
        for (int n = 0; n < 600; n++) begin
            int unsigned kind;
            logic [4:0] rs, rt, rd;
            logic [15:0] off;
            kind = $urandom_range(0, 4);
            rs = 5'($urandom_range(0, 7));
            rt = 5'($urandom_range(0, 7));
            rd = 5'($urandom_range(0, 7));
            if (rpc > 32'd100) kind = 4;
            case (kind)
                0: do_rtype(rs, rt, rd, 3'($urandom_range(0, 4)));
                1: do_load(rt, 16'($urandom_range(128, 255)));
                2: do_store(rt, 16'($urandom_range(128, 255)), "R6 random store data");
                3: begin
                    if ($urandom_range(0, 1) == 1) rt = rs;
                    if (rpc < 32'd16) off = 16'($urandom_range(0, 7));
                    else off = 16'($signed($urandom_range(0, 15)) - 8);
                    do_branch(rs, rt, off, "R8 random branch");
                end
                default: do_jump(26'($urandom_range(0, 99)));
            endcase
        end
        for (int r = 0; r < 32; r++) do_store(5'(r), 16'(128 + r), "R3 final register dump");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule